// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a single down-counter with a small word-addressed register port. Each enabled tick moves the count down by one. The ticks come from an external tick-enable input, divided by 1, 16 or 256. The counter can run in three ways. In free-running mode it wraps over its full 16-bit or 32-bit range. In periodic mode it restarts from a programmed reload value. In one-shot mode it stops at zero. When the count reaches zero a raw interrupt flag is set. That flag, gated by an interrupt enable bit, drives a level interrupt output.

Software writes and reads registers through a request channel that uses valid/ready. Ready is always high, so a request is accepted in the cycle its valid is high. A read returns its data one cycle later on a response channel with a valid flag. The response channel cannot push back, and a write produces no response. Software can reload the counter at once through the reload register. It can also stage a background reload value that the counter picks up only at its next wrap.

Top module: `tmr_top`

## Requirements
- R1: After reset the control word reads 0x20 (interrupt enable set, timer stopped), the count and reload value read 0, the raw flag is clear and `irq` is low.
- R2: Word offsets are: 0 reload (immediate), 1 count (read-only, writes ignored), 2 control, 3 interrupt clear (write-only, reads 0), 4 raw flag in bit 0, 5 masked flag in bit 0, 6 background reload. Offsets 0 and 6 both read the stored reload value. Reads of offsets 7 and above return 0, and writes to them change nothing.
- R3: Control bits are: bit 7 run, bit 6 periodic, bit 5 interrupt enable, bits 3:2 prescale, bit 1 wide (set for 32-bit, clear for 16-bit), bit 0 one-shot.
- R4: A write to offset 0 stores the value and loads the count in the same cycle. In periodic or one-shot mode the count takes the value, masked to the counter width. In free-running mode it takes the full-range value.
- R5: A write to offset 6 stores the reload value and leaves the count unchanged. The next periodic wrap loads the new value.
- R6: While the run bit is set, each prescaled tick lowers the count by one. While it is clear, the count holds.
- R7: The prescale field selects the divisor: 0 divides by 1, 1 by 16, 2 by 256, and 3 acts as 1. Any write to the control register clears the prescale counter.
- R8: When a tick takes the count from 1 to 0, the raw flag is set. In periodic or free-running mode, the next tick at zero reloads the count.
- R9: In one-shot mode (bit 0 set) the count stays at 0 after expiry and sets no further flags.
- R10: With bits 0 and 6 both clear, the counter is free-running. It reloads to 0xFFFF in 16-bit mode and to 0xFFFFFFFF in 32-bit mode.
- R11: A control write with the run bit set loads the count from the reload target.
- R12: Any write to offset 3 clears the raw flag. If an expiry happens in the same cycle, the flag stays set.
- R13: `irq` and the masked status both equal the raw flag ANDed with the interrupt enable bit.
- R14: `req_ready` is always high. A read accepted at one clock edge has `rsp_valid` high with its data for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word offset |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| tick_en | input | 1 | Input tick enable before the prescaler |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is the free-running wrap in 16-bit mode. It needs 65535 ticks before the count reaches zero. The bench holds `tick_en` high for exactly that many cycles, checks the flag, then gives one more tick and checks the reload to 0xFFFF. Two other cases need exact timing. For the clear-versus-expiry case, the bench sends the final tick and the clear write at the same edge. For the divide-by-256 case, it counts out 255 ticks that must not move the count, then one more that must.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic       run;
    logic       periodic;
    logic       irq_en;
    logic       spare;
    logic [1:0] presc;
    logic       wide;
    logic       oneshot;
  } tmr_ctrl_t;

  localparam logic [7:0] CTRL_RESET = 8'h20;

  localparam int OFF_LOAD   = 0;
  localparam int OFF_VALUE  = 1;
  localparam int OFF_CTRL   = 2;
  localparam int OFF_ICLR   = 3;
  localparam int OFF_RIS    = 4;
  localparam int OFF_MIS    = 5;
  localparam int OFF_BGLOAD = 6;
  localparam int NUM_OFFS   = 8;

  typedef enum logic [1:0] {
    PRE_DIV1   = 2'd0,
    PRE_DIV16  = 2'd1,
    PRE_DIV256 = 2'd2,
    PRE_RSVD   = 2'd3
  } tmr_pre_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] count_q,
  input  logic              expire,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output tmr_ctrl_t         ctrl_q,
  output tmr_ctrl_t         ctrl_d,
  output logic [DATA_W-1:0] load_d,
  output logic              wr_load,
  output logic              wr_ctrl,
  output logic              raw_flag
);
  logic [NUM_OFFS-1:0] wr_sel;
  logic [DATA_W-1:0]   load_q;
  logic [DATA_W-1:0]   rd_mux;
  logic                wr_any;

  assign wr_any = req_valid && req_write;

  for (genvar g = 0; g < NUM_OFFS; g++) begin : g_dec
    assign wr_sel[g] = wr_any && (req_addr == ADDR_W'(g));
  end

  assign ctrl_d  = wr_sel[OFF_CTRL] ? tmr_ctrl_t'(req_wdata[7:0]) : ctrl_q;
  assign load_d  = (wr_sel[OFF_LOAD] || wr_sel[OFF_BGLOAD]) ? req_wdata : load_q;
  assign wr_load = wr_sel[OFF_LOAD];
  assign wr_ctrl = wr_sel[OFF_CTRL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= tmr_ctrl_t'(CTRL_RESET);
      load_q   <= '0;
      raw_flag <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      load_q <= load_d;
      if (expire)                raw_flag <= 1'b1;
      else if (wr_sel[OFF_ICLR]) raw_flag <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (req_addr == ADDR_W'(OFF_LOAD) || req_addr == ADDR_W'(OFF_BGLOAD))
      rd_mux = load_q;
    else if (req_addr == ADDR_W'(OFF_VALUE))
      rd_mux = count_q;
    else if (req_addr == ADDR_W'(OFF_CTRL))
      rd_mux = DATA_W'(ctrl_q);
    else if (req_addr == ADDR_W'(OFF_RIS))
      rd_mux = DATA_W'(raw_flag);
    else if (req_addr == ADDR_W'(OFF_MIS))
      rd_mux = DATA_W'(raw_flag && ctrl_q.irq_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int SHIFT_MID = 4,
  parameter int SHIFT_HI  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic       tick_en,
  input  logic [1:0] sel,
  output logic       ptick
);
  localparam int PRE_W = SHIFT_HI;
  localparam logic [PRE_W-1:0] MID_MASK = PRE_W'((1 << SHIFT_MID) - 1);
  localparam logic [PRE_W-1:0] HI_MASK  = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q;
  logic             hit;

  always_comb begin
    unique case (tmr_pre_e'(sel))
      PRE_DIV16:  hit = (pre_q & MID_MASK) == MID_MASK;
      PRE_DIV256: hit = pre_q == HI_MASK;
      default:    hit = 1'b1;
    endcase
  end

  assign ptick = run && tick_en && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pre_q <= '0;
    else if (clr)            pre_q <= '0;
    else if (run && tick_en) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_ctrl_t         ctrl_q,
  input  tmr_ctrl_t         ctrl_d,
  input  logic [DATA_W-1:0] load_d,
  input  logic              wr_load,
  input  logic              wr_ctrl,
  input  logic              ptick,
  output logic [DATA_W-1:0] count_q,
  output logic              expire
);
  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [DATA_W-1:0] WIDE_MASK   = {DATA_W{1'b1}};

  logic [DATA_W-1:0] mask_d, mask_q, reload_tgt, cur;
  logic              free_d, is_zero, is_one, tick_go;

  assign mask_d     = ctrl_d.wide ? WIDE_MASK : NARROW_MASK;
  assign mask_q     = ctrl_q.wide ? WIDE_MASK : NARROW_MASK;
  assign free_d     = !ctrl_d.periodic && !ctrl_d.oneshot;
  assign reload_tgt = free_d ? mask_d : (load_d & mask_d);

  assign cur     = count_q & mask_q;
  assign is_zero = cur == '0;
  assign is_one  = cur == DATA_W'(1);
  assign tick_go = ptick && !wr_load && !wr_ctrl;
  assign expire  = tick_go && is_one;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (wr_load) begin
      count_q <= reload_tgt;
    end else if (wr_ctrl) begin
      if (ctrl_d.run) count_q <= reload_tgt;
    end else if (tick_go) begin
      if (is_zero) begin
        if (!ctrl_q.oneshot) count_q <= reload_tgt;
      end else begin
        count_q <= (cur - 1'b1) & mask_q;
      end
    end
  end
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NARROW_W  = 16,
  parameter int ADDR_W    = 4,
  parameter int SHIFT_MID = 4,
  parameter int SHIFT_HI  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              tick_en,
  output logic              irq
);
  tmr_ctrl_t         ctrl_q, ctrl_d;
  logic [DATA_W-1:0] load_d, count_q;
  logic              wr_load, wr_ctrl, raw_flag, expire, ptick;

  assign req_ready = 1'b1;
  assign irq       = raw_flag && ctrl_q.irq_en;

  tmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .count_q(count_q), .expire(expire),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ctrl_q(ctrl_q), .ctrl_d(ctrl_d),
    .load_d(load_d), .wr_load(wr_load), .wr_ctrl(wr_ctrl), .raw_flag(raw_flag)
  );

  tmr_prescale #(.SHIFT_MID(SHIFT_MID), .SHIFT_HI(SHIFT_HI)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .clr(wr_ctrl),
    .tick_en(tick_en), .sel(ctrl_q.presc), .ptick(ptick)
  );

  tmr_counter #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .ctrl_d(ctrl_d), .load_d(load_d),
    .wr_load(wr_load), .wr_ctrl(wr_ctrl), .ptick(ptick),
    .count_q(count_q), .expire(expire)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              irq,
  input tmr_ctrl_t         ctrl_q,
  input logic [DATA_W-1:0] count_q,
  input logic              raw_flag,
  input logic              expire
);
  logic wr_any, rd_any;
  assign wr_any = req_valid && req_write;
  assign rd_any = req_valid && !req_write;

  AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> rsp_valid); // R14
  AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> !rsp_valid); // R14
  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !wr_any) |=> $stable(count_q)); // R6
  AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.run && ctrl_q.oneshot && count_q == '0 && !wr_any) |=> count_q == '0); // R9
  AST_EXPIRY_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> raw_flag); // R8
  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && req_addr == ADDR_W'(OFF_ICLR) && !expire) |=> !raw_flag); // R12
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl_q.irq_en && raw_flag)); // R13
endmodule

bind tmr_top tmr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .irq(irq), .ctrl_q(ctrl_q),
  .count_q(count_q), .raw_flag(raw_flag), .expire(expire)
);

// File: tb/tmr_top_tb_top.sv
module tmr_top_tb_top;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, tick_en = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, irq;
  logic [DW-1:0] rsp_rdata;
  int            total = 0, bad = 0;
  logic [DW-1:0] rd;

  always #2.5 clk = ~clk;

  tmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .tick_en(tick_en), .irq(irq)
  );

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rdreg(input int a, output logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
    @(negedge clk);
    req_valid = 1'b0;
    if (!rsp_valid) begin
      total++; bad++;
      $display("FAIL R14 got rsp_valid=0 exp=1");
    end
    d = rsp_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R14 ready", DW'(req_ready), 1);
    check("R1 irq", DW'(irq), 0);
    rdreg(2, rd); check("R1 ctrl", rd, 32'h20);
    rdreg(1, rd); check("R1 count", rd, 0);
    rdreg(0, rd); check("R1 load", rd, 0);
    rdreg(4, rd); check("R1 raw", rd, 0);
    rdreg(3, rd); check("R2 iclr reads 0", rd, 0);
  endtask

  task automatic t_periodic;
    wr(2, 32'h62);
    wr(0, 5);
    rdreg(1, rd); check("R4 immediate load", rd, 5);
    ticks(3);
    rdreg(1, rd); check("R6 stopped holds", rd, 5);
    wr(2, 32'hE2);
    ticks(4);
    rdreg(1, rd); check("R6 decrement", rd, 1);
    check("R8 no irq yet", DW'(irq), 0);
    ticks(1);
    rdreg(4, rd); check("R8 raw set", rd, 1);
    check("R13 irq high", DW'(irq), 1);
    rdreg(5, rd); check("R13 masked", rd, 1);
    ticks(1);
    rdreg(1, rd); check("R8 periodic reload", rd, 5);
    wr(2, 32'hC2);
    check("R13 irq masked", DW'(irq), 0);
    rdreg(5, rd); check("R13 mis masked", rd, 0);
    rdreg(4, rd); check("R13 raw kept", rd, 1);
    wr(3, 0);
    rdreg(4, rd); check("R12 clear", rd, 0);
  endtask

  task automatic t_background;
    wr(2, 32'hE2);
    wr(0, 3);
    wr(6, 7);
    rdreg(1, rd); check("R5 count untouched", rd, 3);
    rdreg(0, rd); check("R2 off0 reload", rd, 7);
    rdreg(6, rd); check("R2 off6 reload", rd, 7);
    ticks(4);
    rdreg(1, rd); check("R5 new reload at wrap", rd, 7);
    wr(3, 0);
  endtask

  task automatic t_clear_race;
    wr(2, 32'hE2);
    wr(0, 2);
    ticks(1);
    @(negedge clk);
    tick_en = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(3);
    @(negedge clk);
    tick_en = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    rdreg(4, rd); check("R12 expiry beats clear", rd, 1);
    wr(3, 0);
  endtask

  task automatic t_oneshot;
    wr(6, 2);
    wr(2, 32'hA3);
    rdreg(1, rd); check("R11 enable loads", rd, 2);
    ticks(2);
    rdreg(4, rd); check("R8 oneshot expiry", rd, 1);
    wr(3, 0);
    ticks(3);
    rdreg(1, rd); check("R9 parked", rd, 0);
    rdreg(4, rd); check("R9 no refire", rd, 0);
    wr(2, 32'hA3);
    rdreg(1, rd); check("R11 re-enable reload", rd, 2);
  endtask

  task automatic t_prescale;
    wr(6, 5);
    wr(2, 32'hE6);
    ticks(15);
    rdreg(1, rd); check("R7 div16 hold", rd, 5);
    ticks(1);
    rdreg(1, rd); check("R7 div16 step", rd, 4);
    wr(2, 32'hEA);
    ticks(255);
    rdreg(1, rd); check("R7 div256 hold", rd, 5);
    ticks(1);
    rdreg(1, rd); check("R7 div256 step", rd, 4);
    wr(2, 32'hEE);
    ticks(2);
    rdreg(1, rd); check("R7 code3 div1", rd, 3);
  endtask

  task automatic t_free;
    wr(2, 32'h82);
    rdreg(1, rd); check("R10 free 32b", rd, 32'hFFFF_FFFF);
    wr(0, 9);
    rdreg(1, rd); check("R4 free ignores load", rd, 32'hFFFF_FFFF);
    wr(2, 32'h80);
    rdreg(1, rd); check("R10 free 16b", rd, 32'hFFFF);
    ticks(65535);
    rdreg(1, rd); check("R10 reached zero", rd, 0);
    rdreg(4, rd); check("R8 free flag", rd, 1);
    ticks(1);
    rdreg(1, rd); check("R10 wrap 16b", rd, 32'hFFFF);
    rdreg(2, rd); check("R3 ctrl readback", rd, 32'h80);
  endtask

  task automatic t_ignored;
    wr(2, 32'h62);
    wr(0, 32'h44);
    wr(1, 32'h1234);
    rdreg(1, rd); check("R2 value write ignored", rd, 32'h44);
    wr(9, 32'hFF);
    rdreg(2, rd); check("R2 unmapped write", rd, 32'h62);
    rdreg(0, rd); check("R2 unmapped write load", rd, 32'h44);
    rdreg(7, rd); check("R2 unmapped read", rd, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_periodic();
        t_background();
        t_clear_race();
        t_oneshot();
        t_prescale();
        t_free();
        t_ignored();
      end
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog got=timeout exp=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule